// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator with Repeat Masks

This block holds a four-byte alarm (seconds, minutes, hours, day of month, all in BCD) and compares it against a running BCD time of day. The time of day comes from a separate calendar block. The comparison is made only on the cycles where a once-per-second tick input is high.

Bit 7 of each alarm byte is a repeat mask. The pattern of masks picks how often the alarm fires: monthly, daily, hourly, every minute or every second.

The host loads the alarm bytes and a control byte through a byte write port and can read any of them back. A write carrying a BCD value outside the legal range of its field is dropped, and the register keeps its old value. When the alarm matches on a tick and the alarm enable bit is set, the block emits a single-cycle interrupt pulse.

Top module: `alarm_match`

## Requirements
- R1: After reset, all five registers (selects 0 to 4) read 0x00 and `irq` is low.
- R2: A write to select 0 (seconds) or select 1 (minutes) is decoded as tens = bits 6:4 and ones = bits 3:0, giving the value tens*10+ones. If that value is 59 or less, the whole byte is stored, bit 7 included. Otherwise the register is left unchanged.
- R3: A write to select 2 (hours) is decoded as tens = bits 5:4 and ones = bits 3:0. The whole byte is stored only if tens*10+ones is 23 or less.
- R4: A write to select 3 (date) is decoded as tens = bits 5:4 and ones = bits 3:0. The whole byte is stored only if tens*10+ones is nonzero.
- R5: Select 4 is the control byte. Every write to it is stored, and bit 7 is the alarm enable. Writes to selects 5 to 7 change nothing, and reads of those selects return 0x00.
- R6: `rd_data` shows the stored byte of the register named by `rd_sel` in the same cycle, with no added delay.
- R7: With all four mask bits clear, a match needs these fields to be equal: date bits 5:0, hour bits 5:0, minute bits 6:0 and second bits 6:0, each against the same bits of the time-of-day input.
- R8: With only the date mask set, a match needs hour, minute and second to be equal.
- R9: With the date and hour masks set and the other two clear, a match needs minute and second to be equal.
- R10: With the date, hour and minute masks set and the seconds mask clear, a match needs only the second to be equal.
- R11: Every other mask pattern matches on every tick.
- R12: `irq` goes high for the cycle after a clock edge where `tick` is high, the alarm matches and the enable bit is set. With `tick` low or the enable clear, `irq` stays low.
- R13: `irq` is never high in two consecutive cycles, even when `tick` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 8 | Write data byte |
| rd_sel | input | 3 | Register select for the read |
| rd_data | output | 8 | Read data byte |
| tick | input | 1 | Once-per-second compare enable |
| tod_sec | input | 8 | Current seconds, BCD |
| tod_min | input | 8 | Current minutes, BCD |
| tod_hour | input | 8 | Current hours, BCD |
| tod_date | input | 8 | Current day of month, BCD |
| irq | output | 1 | Alarm interrupt pulse |

## Verification
The hardest case to reach is a match under one specific mask pattern where the fields being ignored differ while the fields being compared agree. Purely random time values almost never produce an equal field.

To reach it, the stimulus builds each time-of-day value from the stored alarm bytes. It then randomly perturbs individual fields, so that both matching and non-matching values occur in every repeat mode.

Invalid BCD writes are mixed into the stream. The mask patterns rely on a prior accepted write, so a rejected write shows up as a wrong repeat mode if the block mishandles it.

// File: rtl/alarm_match.sv
module alarm_match #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [7:0]       wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [7:0]       rd_data,
  input  logic             tick,
  input  logic [7:0]       tod_sec,
  input  logic [7:0]       tod_min,
  input  logic [7:0]       tod_hour,
  input  logic [7:0]       tod_date,
  output logic             irq
);

  logic [7:0] a_sec, a_min, a_hour, a_date, ctl;
  logic       match;

  function automatic logic [6:0] bcd_val(input logic [2:0] t, input logic [3:0] o);
    return 7'(t) * 7'd10 + 7'(o);
  endfunction

  wire [6:0] v7 = bcd_val(wr_data[6:4], wr_data[3:0]);
  wire [6:0] v6 = bcd_val({1'b0, wr_data[5:4]}, wr_data[3:0]);
  wire ok_ms   = v7 <= 7'd59;
  wire ok_hour = v6 <= 7'd23;
  wire ok_date = v6 != 7'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_sec  <= '0;
      a_min  <= '0;
      a_hour <= '0;
      a_date <= '0;
      ctl    <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        3'd0: if (ok_ms)   a_sec  <= wr_data;
        3'd1: if (ok_ms)   a_min  <= wr_data;
        3'd2: if (ok_hour) a_hour <= wr_data;
        3'd3: if (ok_date) a_date <= wr_data;
        3'd4: ctl <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_sel)
      3'd0:    rd_data = a_sec;
      3'd1:    rd_data = a_min;
      3'd2:    rd_data = a_hour;
      3'd3:    rd_data = a_date;
      3'd4:    rd_data = ctl;
      default: rd_data = '0;
    endcase
  end

  wire eq_s = a_sec[6:0]  == tod_sec[6:0];
  wire eq_m = a_min[6:0]  == tod_min[6:0];
  wire eq_h = a_hour[5:0] == tod_hour[5:0];
  wire eq_d = a_date[5:0] == tod_date[5:0];

  always_comb begin
    case ({a_date[7], a_hour[7], a_min[7], a_sec[7]})
      4'b0000: match = eq_d & eq_h & eq_m & eq_s;
      4'b1000: match = eq_h & eq_m & eq_s;
      4'b1100: match = eq_m & eq_s;
      4'b1110: match = eq_s;
      default: match = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= tick & match & ctl[7] & ~irq;
  end

endmodule

module alarm_match_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_sel,
  input logic [7:0] wr_data,
  input logic       tick,
  input logic [7:0] a_sec,
  input logic [7:0] a_hour,
  input logic [7:0] ctl,
  input logic       irq
);
  wire [6:0] s_val = 7'(wr_data[6:4]) * 7'd10 + 7'(wr_data[3:0]);
  wire [6:0] h_val = 7'(wr_data[5:4]) * 7'd10 + 7'(wr_data[3:0]);

  AST_SEC_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0 && s_val > 7'd59) |=> $stable(a_sec)); // R2
  AST_SEC_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0 && s_val <= 7'd59) |=> a_sec == $past(wr_data)); // R2
  AST_HOUR_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd2 && h_val > 7'd23) |=> $stable(a_hour)); // R3
  AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick) && $past(ctl[7])); // R12
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R13
endmodule

bind alarm_match alarm_match_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .tick(tick), .a_sec(a_sec), .a_hour(a_hour), .ctl(ctl), .irq(irq)
);

// File: tb/alarm_match_bench.sv
`timescale 1ns/1ps
module alarm_match_bench;
  logic       clk = 0, rst_n = 0, wr_en = 0, tick = 0;
  logic [2:0] wr_sel = 0, rd_sel = 0;
  logic [7:0] wr_data = 0, tod_sec = 0, tod_min = 0, tod_hour = 0, tod_date = 0;
  logic [7:0] rd_data;
  logic       irq;
  int errors = 0, checks = 0;
  logic [7:0] m [0:4];

  always #2.5 clk = ~clk;

  alarm_match u_alarm_match (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit legal(input int sel, input logic [7:0] d);
    int t7 = d[6:4] * 10 + d[3:0];
    int t6 = d[5:4] * 10 + d[3:0];
    case (sel)
      0, 1: return t7 <= 59;
      2:    return t6 <= 23;
      3:    return t6 != 0;
      4:    return 1;
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_match(input logic [7:0] s, mi, h, d);
    bit es = m[0][6:0] == s[6:0], em = m[1][6:0] == mi[6:0];
    bit eh = m[2][5:0] == h[5:0], ed = m[3][5:0] == d[5:0];
    logic [3:0] k = {m[3][7], m[2][7], m[1][7], m[0][7]};
    if (k == 4'b0000) return ed && eh && em && es;
    if (k == 4'b1000) return eh && em && es;
    if (k == 4'b1100) return em && es;
    if (k == 4'b1110) return es;
    return 1;
  endfunction

  task automatic wr(input int sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = 3'(sel); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (sel < 5 && legal(sel, d)) m[sel] = d;
  endtask

  task automatic rd_all(input string req);
    for (int i = 0; i < 8; i++) begin
      rd_sel = 3'(i); #0.5;
      check(req, rd_data, i < 5 ? m[i] : 8'h00);
    end
  endtask

  task automatic do_tick(input logic [7:0] s, mi, h, d, input string req);
    bit e;
    @(negedge clk);
    tod_sec = s; tod_min = mi; tod_hour = h; tod_date = d; tick = 1;
    e = exp_match(s, mi, h, d) && m[4][7];
    @(negedge clk);
    tick = 0;
    check(req, {7'b0, irq}, {7'b0, e});
    @(negedge clk);
    check("R13", {7'b0, irq}, 8'h00);
  endtask

  function automatic logic [7:0] bump(input logic [7:0] v, input bit doit);
    return doit ? (v ^ 8'h01) : v;
  endfunction

  initial begin
    #900000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234));
    for (int i = 0; i < 5; i++) m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1", {7'b0, irq}, 8'h00);
    rd_all("R1");
    // R2 R3 R4 directed legal and illegal writes
    wr(0, 8'h59); wr(0, 8'h60); wr(0, 8'h1F);
    wr(1, 8'hD9); wr(1, 8'h7A);
    wr(2, 8'h23); wr(2, 8'h24); wr(2, 8'h1A);
    wr(3, 8'h00); wr(3, 8'h31); wr(3, 8'h40);
    rd_all("R2/R3/R4 R6");
    wr(5, 8'hFF); wr(7, 8'h12);
    rd_all("R5");
    // R12 enable clear suppresses
    wr(0, 8'h10); wr(1, 8'h20); wr(2, 8'h05); wr(3, 8'h12); wr(4, 8'h00);
    do_tick(8'h10, 8'h20, 8'h05, 8'h12, "R12");
    wr(4, 8'h80);
    do_tick(8'h10, 8'h20, 8'h05, 8'h12, "R7");
    do_tick(8'h10, 8'h20, 8'h05, 8'h13, "R7");
    // R12 no tick no irq
    @(negedge clk); tod_sec = 8'h10;
    @(negedge clk); check("R12", {7'b0, irq}, 8'h00);
    // R8 daily
    wr(3, 8'h92);
    do_tick(8'h10, 8'h20, 8'h05, 8'h01, "R8");
    do_tick(8'h10, 8'h20, 8'h06, 8'h01, "R8");
    // R9 hourly
    wr(2, 8'h85);
    do_tick(8'h10, 8'h20, 8'h11, 8'h01, "R9");
    do_tick(8'h10, 8'h21, 8'h11, 8'h01, "R9");
    // R10 minute
    wr(1, 8'hA0);
    do_tick(8'h10, 8'h44, 8'h11, 8'h01, "R10");
    do_tick(8'h11, 8'h44, 8'h11, 8'h01, "R10");
    // R11 all masked
    wr(0, 8'h90);
    do_tick(8'h33, 8'h44, 8'h11, 8'h01, "R11");
    // R13 tick held high
    @(negedge clk); tick = 1;
    @(negedge clk); check("R13", {7'b0, irq}, 8'h01);
    @(negedge clk); check("R13", {7'b0, irq}, 8'h00);
    tick = 0;
    // random mix
    for (int n = 0; n < 400; n++) begin
      int sel = $urandom_range(0, 5);
      logic [7:0] d = 8'($urandom);
      if ($urandom_range(0, 2) != 0 && sel < 4)
        d = {d[7], 3'($urandom_range(0, sel == 2 ? 2 : 5)), 4'($urandom_range(0, 9))};
      if (sel == 4) d[7] = ($urandom_range(0, 3) != 0);
      wr(sel, d);
      if (n % 8 == 0) rd_all("R6");
      do_tick(bump(m[0], $urandom_range(0, 3) == 0), bump(m[1], $urandom_range(0, 3) == 0),
              bump(m[2], $urandom_range(0, 3) == 0), bump(m[3], $urandom_range(0, 3) == 0),
              "R7-R12 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule